// File: doc/BRIEF.md
# Periodic Countdown Timer with Interrupt Pulse

This block counts down a 12-bit programmed period and raises an event each time the period runs out. The period is written as two fields: an 8-bit low part and a 4-bit high part. The countdown advances on one of four prescaled time bases. Each time base arrives as a single-cycle enable strobe. A 2-bit code selects which strobe is used.

Counting is enabled by one control bit. When the enable rises, the counter takes the period value. At each selected strobe the counter steps down by one. When a step would bring it to zero, the counter instead reloads the period, sets a sticky event flag, and, if interrupt output is allowed, drives an active-low interrupt line for a fixed number of system clock cycles.

Software clears the flag through a clear input. The interrupt pulse ends on its own and does not wait for the flag to be cleared. The current count is brought out so that the countdown can be observed.

Top module: `cycle_timer`

## Requirements
- R1: After reset the count is 0, the event flag is 0 and `intN` is 1.
- R2: On the first clock edge at which `timerEn` is 1 after having been 0, the count loads the period `{periodHi, periodLo}`, where `periodHi` supplies bits 11:8 and `periodLo` supplies bits 7:0.
- R3: While counting, only the strobe selected by `srcSel` changes the count. A strobe on any other bit of `srcTicks` leaves the count unchanged.
- R4: `srcSel` code 0 selects `srcTicks[0]` (4096 Hz), code 1 selects `srcTicks[1]` (64 Hz), code 2 selects `srcTicks[2]` (seconds) and code 3 selects `srcTicks[3]` (minutes).
- R5: A selected strobe that arrives while the count is greater than 1 lowers the count by one. A selected strobe that arrives while the count is 1 reloads the period and sets the event flag, both at the same clock edge.
- R6: A period of 0 never produces an event. The count stays at 0 through any number of strobes.
- R7: On an event with `intEn` equal to 1, `intN` is 0 from that edge for exactly 128 system clock cycles and then returns to 1. Clearing the flag during the pulse does not shorten it.
- R8: On an event with `intEn` equal to 0, the flag still sets and `intN` stays 1.
- R9: While `timerEn` is 0, strobes leave the count unchanged. Lowering `timerEn` forces `intN` to 1 at once and ends any pulse in progress.
- R10: The flag stays set until `flagClr` is 1 at a clock edge. If an event and `flagClr` occur at the same edge, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcTicks | input | 4 | Single-cycle strobes of the four time bases, indexed by select code |
| srcSel | input | 2 | Time base select code |
| periodLo | input | 8 | Period bits 7:0 |
| periodHi | input | 4 | Period bits 11:8 |
| timerEn | input | 1 | Counting enable |
| intEn | input | 1 | Allows the interrupt pulse |
| flagClr | input | 1 | Clears the event flag |
| count | output | 12 | Current countdown value |
| timerFlag | output | 1 | Sticky event flag |
| intN | output | 1 | Interrupt output, active low |

## Verification
Every result is registered, so each effect is due exactly one clock edge after the stimulus that causes it:
- the period load follows the first edge at which the enable is high;
- the count step, the reload, the flag and the start of the pulse follow the edge that captures the strobe;
- the release of `intN` is due 128 edges after the event.

The only effect with no edge in between is that lowering the enable releases `intN` within the same cycle.

The bench drives inputs one nanosecond after a rising edge and samples just after the following rising edge. For the pulse length it counts edges, checking `intN` at edge 127 and again at edge 128 after the event. It checks the release on enable removal before any further edge.

// File: rtl/cyctmr_pkg.sv
package cyctmr_pkg;
  // Strobes from the control module to the counter datapath
  typedef struct packed {
    logic load;    // take the period after enable rises
    logic dec;     // step down by one
    logic reload;  // expiry: take the period again
  } cnt_ctl_t;
endpackage

// File: rtl/cyctmr_datapath.sv
module cyctmr_datapath
  import cyctmr_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  cnt_ctl_t         ctl,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             atOne,
  output logic             isZero
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      count <= '0;
    else if (ctl.load || ctl.reload)
      count <= period;
    else if (ctl.dec)
      count <= count - CNT_W'(1);
  end

  assign atOne  = (count == CNT_W'(1));
  assign isZero = (count == '0);

  // R6: an empty counter stays empty unless it is loaded
  a_r6_zero_holds: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0 && !ctl.load) |=> (count == '0));

  // R5: expiry happens only on the last step and takes the period
  a_r5_reload_at_one: assert property (@(posedge clk) disable iff (!rstN)
    ctl.reload |-> (count == CNT_W'(1)));
  a_r5_reload_value: assert property (@(posedge clk) disable iff (!rstN)
    ctl.reload |=> (count == $past(period)));

endmodule

// File: rtl/cyctmr_control.sv
module cyctmr_control
  import cyctmr_pkg::*;
#(
  parameter int SEL_W     = 2,
  parameter int PULSE_CYC = 128
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [(1<<SEL_W)-1:0]   srcTicks,
  input  logic [SEL_W-1:0]        srcSel,
  input  logic                    timerEn,
  input  logic                    intEn,
  input  logic                    flagClr,
  input  logic                    atOne,
  input  logic                    isZero,
  output cnt_ctl_t                ctl,
  output logic                    timerFlag,
  output logic                    intN
);

  localparam int NUM_SRC = 1 << SEL_W;
  localparam int PW      = $clog2(PULSE_CYC + 1);

  logic               teQ;
  logic [NUM_SRC-1:0] selHit;
  logic               tick;
  logic [PW-1:0]      pulseCnt;

  // One gate per time base: pass the strobe only when it is the selected one
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign selHit[g] = srcTicks[g] && (srcSel == SEL_W'(g));
  end

  // Counting only after the load edge has been taken
  assign tick = timerEn && teQ && (|selHit);

  assign ctl.load   = timerEn && !teQ;
  assign ctl.reload = tick && atOne;
  assign ctl.dec    = tick && !atOne && !isZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) teQ <= 1'b0;
    else       teQ <= timerEn;
  end

  // Sticky event flag; a new event wins over a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           timerFlag <= 1'b0;
    else if (ctl.reload) timerFlag <= 1'b1;
    else if (flagClr)    timerFlag <= 1'b0;
  end

  // Fixed-length interrupt pulse, independent of the flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     pulseCnt <= '0;
    else if (!timerEn)             pulseCnt <= '0;
    else if (ctl.reload && intEn)  pulseCnt <= PW'(PULSE_CYC);
    else if (pulseCnt != '0)       pulseCnt <= pulseCnt - PW'(1);
  end

  assign intN = !(timerEn && (pulseCnt != '0));

  // R9: no counter activity while disabled, and the line is released
  a_r9_idle_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !timerEn |-> (!ctl.load && !ctl.dec && !ctl.reload && intN));

  // R3: any count change comes from the selected strobe
  a_r3_selected_source: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.dec || ctl.reload) |-> srcTicks[srcSel]);

  // R7: an allowed event pulls the line low on the next cycle
  a_r7_pulse_starts: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.reload && intEn && timerEn) |=> (!intN || !timerEn));

  // R8: without permission an event does not pull the line low
  a_r8_no_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.reload && !intEn && intN) |=> intN);

  // R10: the flag changes only on an event or a clear
  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.reload && !flagClr) |=> $stable(timerFlag));

endmodule

// File: rtl/cycle_timer.sv
module cycle_timer
  import cyctmr_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int LO_W      = 8,
  parameter int SEL_W     = 2,
  parameter int PULSE_CYC = 128
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [(1<<SEL_W)-1:0] srcTicks,
  input  logic [SEL_W-1:0]      srcSel,
  input  logic [LO_W-1:0]       periodLo,
  input  logic [CNT_W-LO_W-1:0] periodHi,
  input  logic                  timerEn,
  input  logic                  intEn,
  input  logic                  flagClr,
  output logic [CNT_W-1:0]      count,
  output logic                  timerFlag,
  output logic                  intN
);

  cnt_ctl_t         ctl;
  logic             atOne;
  logic             isZero;
  logic [CNT_W-1:0] period;

  assign period = {periodHi, periodLo};

  cyctmr_control #(.SEL_W(SEL_W), .PULSE_CYC(PULSE_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .srcTicks(srcTicks), .srcSel(srcSel),
    .timerEn(timerEn), .intEn(intEn), .flagClr(flagClr),
    .atOne(atOne), .isZero(isZero), .ctl(ctl),
    .timerFlag(timerFlag), .intN(intN)
  );

  cyctmr_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .period(period),
    .count(count), .atOne(atOne), .isZero(isZero)
  );

endmodule

// File: tb/cycle_timer_test.sv
module cycle_timer_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  srcTicks;
  logic [1:0]  srcSel;
  logic [7:0]  periodLo;
  logic [3:0]  periodHi;
  logic        timerEn, intEn, flagClr;
  logic [11:0] count;
  logic        timerFlag, intN;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  cycle_timer uut (
    .clk(clk), .rstN(rstN), .srcTicks(srcTicks), .srcSel(srcSel),
    .periodLo(periodLo), .periodHi(periodHi), .timerEn(timerEn),
    .intEn(intEn), .flagClr(flagClr), .count(count),
    .timerFlag(timerFlag), .intN(intN)
  );

  // Vector: {select code, period}; the event is due at strobe number = period
  localparam logic [13:0] VECS [5] = '{
    {2'd0, 12'd3}, {2'd1, 12'd1}, {2'd2, 12'd5}, {2'd3, 12'd2}, {2'd0, 12'h103}
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // Raise one strobe for one edge; state is sampled right after that edge
  task automatic strobe(logic [3:0] mask);
    srcTicks = mask; step(); srcTicks = '0;
  endtask

  task automatic setPeriod(logic [11:0] p);
    periodHi = p[11:8]; periodLo = p[7:0];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 0; srcTicks = '0; srcSel = '0; periodLo = '0; periodHi = '0;
    timerEn = 0; intEn = 0; flagClr = 0;
    repeat (3) step();
    chk("R1 count", int'(count), 0);
    chk("R1 flag", int'(timerFlag), 0);
    chk("R1 intN", int'(intN), 1);
    rstN = 1; step();

    // Table walk: R2 load, R3 other source ignored, R4 select map, R5 countdown
    for (int v = 0; v < 5; v++) begin
      logic [1:0]  sel;
      logic [11:0] pr;
      sel = VECS[v][13:12]; pr = VECS[v][11:0];
      srcSel = sel; setPeriod(pr); intEn = 1; timerEn = 1;
      step();
      chk("R2 load", int'(count), int'(pr));
      strobe(4'(1) << (sel + 2'd1));
      chk("R3 other source", int'(count), int'(pr));
      for (int i = 1; i <= int'(pr); i++) begin
        strobe(4'(1) << sel);
        if (i == int'(pr)) begin
          chk("R4 R5 reload", int'(count), int'(pr));
          chk("R5 flag set", int'(timerFlag), 1);
          chk("R7 intN low", int'(intN), 0);
        end else begin
          chk("R4 R5 step", int'(count), int'(pr) - i);
          chk("R5 flag quiet", int'(timerFlag), 0);
        end
      end
      timerEn = 0; flagClr = 1; step(); flagClr = 0;
    end

    // R7 pulse length, flag clear does not shorten it
    srcSel = 0; setPeriod(12'd1); intEn = 1; timerEn = 1; step();
    strobe(4'b0001);
    chk("R7 start", int'(intN), 0);
    flagClr = 1; step(); flagClr = 0;
    chk("R10 cleared", int'(timerFlag), 0);
    chk("R7 after clear", int'(intN), 0);
    repeat (126) step();
    chk("R7 edge 127", int'(intN), 0);
    step();
    chk("R7 edge 128", int'(intN), 1);

    // R8 interrupt not allowed
    timerEn = 0; step();
    intEn = 0; setPeriod(12'd2); timerEn = 1; step();
    strobe(4'b0001); strobe(4'b0001);
    chk("R8 flag", int'(timerFlag), 1);
    chk("R8 intN", int'(intN), 1);
    step();
    chk("R8 intN later", int'(intN), 1);

    // R10 sticky and set-wins
    repeat (5) step();
    chk("R10 sticky", int'(timerFlag), 1);
    strobe(4'b0001);
    flagClr = 1; strobe(4'b0001); flagClr = 0;
    chk("R10 set wins", int'(timerFlag), 1);
    flagClr = 1; step(); flagClr = 0;
    chk("R10 clear", int'(timerFlag), 0);

    // R9 disable cancels the pulse at once and freezes the count
    timerEn = 0; step();
    intEn = 1; setPeriod(12'd3); timerEn = 1; step();
    strobe(4'b0001); strobe(4'b0001); strobe(4'b0001);
    chk("R9 pulse on", int'(intN), 0);
    strobe(4'b0001);
    chk("R9 count before", int'(count), 2);
    timerEn = 0; #1;
    chk("R9 release now", int'(intN), 1);
    strobe(4'b0001); strobe(4'b0001);
    chk("R9 frozen", int'(count), 2);
    chk("R9 intN off", int'(intN), 1);
    flagClr = 1; step(); flagClr = 0;

    // R6 zero period
    setPeriod(12'd0); timerEn = 1; step();
    chk("R6 load zero", int'(count), 0);
    for (int i = 0; i < 5; i++) strobe(4'b0001);
    chk("R6 count", int'(count), 0);
    chk("R6 flag", int'(timerFlag), 0);
    chk("R6 intN", int'(intN), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule